// File: doc/BRIEF.md
# Per-flow client word stream formatter

This block sits between a buffer of packets that a TCP flow tracker has accepted for a client application and the client itself. It turns each buffered packet into a 32-bit word stream, one word per enabled clock. Each word comes with sideband signals that let the client rebuild every TCP byte stream without parsing headers: a data-enable, four boundary markers, a count of valid bytes in the closing word, the flow index, and start-of-flow and end-of-flow flags.

Before the packet's own words, the block inserts one extra word that carries the packet's byte length and opens the frame. The upstream buffer supplies the IP and TCP payload offsets, given as word indices within the packet, and a flag for FIN or RST. The tracker sends a separate one-cycle notice when it sees a SYN on a flow. The block keeps one pending bit per flow, so it can flag the first client word that follows such a notice.

The client paces delivery with a single go input. When go is sampled low, the next cycle carries no data and every output holds its value. Upstream words are taken only when the block is ready for them.

Top module: `flow_stream_out`

## Requirements
- R1: While reset is high, and in the first cycle after it with no input valid, out_en, out_mark, out_flow_ev and in_ready are all zero.
- R2: Each packet is delivered as a length word followed by the packet's words in order, one word per cycle with out_en high. The length word has in_len in its low bits and zeros above. Every word of the packet carries the packet's flow index on out_flow.
- R3: The marker bits of out_mark are: bit 0 frame start, on the length word only; bit 1 IP payload start, on the packet word whose index equals in_ip_off; bit 2 TCP payload start, on the word whose index equals in_tcp_off; bit 3 frame end, on the last packet word. Word index 0 is the first packet word after the length word. Each bit appears exactly once per packet.
- R4: On the frame-end word, out_nbytes equals in_len modulo 4, where 0 means all four bytes are valid and 1 to 3 mean that many leading bytes. On every other word it is 0.
- R5: If client_go is low at a clock edge, then in the next cycle out_en is low and out_data, out_mark, out_nbytes, out_flow and out_flow_ev keep their values. While client_go is low, in_ready is low.
- R6: The length word does not consume an upstream word: in_ready is low while the length word is being issued. An upstream word accepted at an edge (in_valid and in_ready high) appears on the outputs in the next cycle with out_en high.
- R7: out_flow_ev bit 0 (start of flow) is set on the length word of the first packet of a flow after a notice for that flow, and is zero on later packets of that flow until a new notice arrives.
- R8: A notice for the flow whose length word is issued in the same cycle applies to that packet and is consumed by it.
- R9: out_flow_ev bit 1 (end of flow) is set on the frame-end word of a packet whose in_fin_rst is high, and is zero on every other word.
- R10: A notice for one flow has no effect on the start-of-flow flag of packets from other flows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| client_go | input | 1 | Client flow control; low holds delivery |
| in_valid | input | 1 | Upstream word valid |
| in_ready | output | 1 | Upstream word taken this cycle when in_valid is high |
| in_data | input | 32 | Upstream packet word |
| in_last | input | 1 | Upstream word is the last of its packet |
| in_flow | input | FLOW_W | Flow index, held for the whole packet |
| in_len | input | LEN_W | Packet length in bytes, held for the whole packet |
| in_ip_off | input | OFF_W | Word index of the IP payload start |
| in_tcp_off | input | OFF_W | Word index of the TCP payload start |
| in_fin_rst | input | 1 | Packet carries FIN or RST |
| note_valid | input | 1 | SYN notice strobe from the tracker |
| note_flow | input | FLOW_W | Flow index of the SYN notice |
| out_en | output | 1 | Client data enable |
| out_data | output | 32 | Client data word |
| out_mark | output | 4 | Boundary markers (see R3) |
| out_nbytes | output | 2 | Valid bytes in the frame-end word (see R4) |
| out_flow | output | FLOW_W | Flow index of the current word |
| out_flow_ev | output | 2 | Bit 0 start of flow, bit 1 end of flow |

## Verification
The bench targets a one-word packet, where IP start, TCP start and frame end fall on the same word. A design that priority-encoded the markers would drop two of them there. It also covers lengths that are and are not multiples of four: a design that mapped a four-byte tail to anything but 0, or reported a tail byte count on inner words, gives the wrong out_nbytes. Client stalls come both in a fixed mid-packet pattern and at random. A design that let data move during a stall would change out_data or pulse out_en while the client had asked it to wait. The start-of-flow checks send a notice in the same cycle as the packet's header, then send a second packet on that flow and interleave other flows. A design missing the bypass would lose the flag, one that never cleared the pending bit would flag it twice, and one that indexed the table wrongly would flag the wrong flow.

// File: rtl/flow_stream_pkg.sv
package flow_stream_pkg;

  localparam int WORD_W  = 32;
  localparam int MARK_W  = 4;
  localparam int NBYTE_W = 2;
  localparam int FEV_W   = 2;

  typedef enum logic {
    SEQ_HEAD = 1'b0,
    SEQ_BODY = 1'b1
  } seq_state_e;

  // bit order is visible on the client port
  typedef struct packed {
    logic frame_end;
    logic tcp_start;
    logic ip_start;
    logic frame_start;
  } mark_t;

  typedef struct packed {
    logic flow_end;
    logic flow_start;
  } fev_t;

endpackage

// File: rtl/flow_start_table.sv
module flow_start_table #(
  parameter int FLOWS  = 256,
  parameter int FLOW_W = $clog2(FLOWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              note_valid,
  input  logic [FLOW_W-1:0] note_flow,
  input  logic              take,
  input  logic [FLOW_W-1:0] take_flow,
  output logic              start_hit
);

  logic pend [FLOWS];
  logic same_flow;

  assign same_flow = note_valid && (note_flow == take_flow);
  // a notice arriving with the header counts for that packet
  assign start_hit = pend[take_flow] || same_flow;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < FLOWS; i++) pend[i] <= 1'b0;
    end else begin
      if (take) pend[take_flow] <= 1'b0;
      if (note_valid && !(take && same_flow)) pend[note_flow] <= 1'b1;
    end
  end

endmodule

// File: rtl/flow_stream_seq.sv
module flow_stream_seq
  import flow_stream_pkg::*;
#(
  parameter int FLOW_W = 8,
  parameter int LEN_W  = 16,
  parameter int OFF_W  = 4,
  localparam int IDX_W = LEN_W - 2,
  localparam int PAD_W = WORD_W - LEN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              client_go,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  input  logic [FLOW_W-1:0] in_flow,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [OFF_W-1:0]  in_ip_off,
  input  logic [OFF_W-1:0]  in_tcp_off,
  input  logic              in_fin_rst,
  input  logic              start_hit,
  output logic              take,
  output logic              issue,
  output logic [WORD_W-1:0] nx_data,
  output mark_t             nx_mark,
  output logic [NBYTE_W-1:0] nx_nbytes,
  output logic [FLOW_W-1:0] nx_flow,
  output fev_t              nx_fev
);

  seq_state_e         st_q;
  logic [IDX_W-1:0]   idx_q;
  logic [FLOW_W-1:0]  flow_q;
  logic [1:0]         tail_q;
  logic [OFF_W-1:0]   ip_q;
  logic [OFF_W-1:0]   tcp_q;
  logic               fr_q;
  logic               in_body;
  logic               ip_hit;
  logic               tcp_hit;

  assign in_body  = (st_q == SEQ_BODY);
  assign in_ready = client_go && in_body;
  assign issue    = client_go && in_valid;
  assign take     = issue && !in_body;

  assign ip_hit  = (idx_q == IDX_W'(ip_q));
  assign tcp_hit = (idx_q == IDX_W'(tcp_q));

  always_comb begin
    if (in_body) begin
      nx_data           = in_data;
      nx_mark.frame_start = 1'b0;
      nx_mark.ip_start  = ip_hit;
      nx_mark.tcp_start = tcp_hit;
      nx_mark.frame_end = in_last;
      nx_nbytes         = in_last ? tail_q : '0;
      nx_flow           = flow_q;
      nx_fev.flow_start = 1'b0;
      nx_fev.flow_end   = in_last && fr_q;
    end else begin
      nx_data           = {{PAD_W{1'b0}}, in_len};
      nx_mark           = '{frame_end: 1'b0, tcp_start: 1'b0,
                            ip_start: 1'b0, frame_start: 1'b1};
      nx_nbytes         = '0;
      nx_flow           = in_flow;
      nx_fev.flow_start = start_hit;
      nx_fev.flow_end   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SEQ_HEAD;
      idx_q  <= '0;
      flow_q <= '0;
      tail_q <= '0;
      ip_q   <= '0;
      tcp_q  <= '0;
      fr_q   <= 1'b0;
    end else if (take) begin
      st_q   <= SEQ_BODY;
      idx_q  <= '0;
      flow_q <= in_flow;
      tail_q <= in_len[1:0];
      ip_q   <= in_ip_off;
      tcp_q  <= in_tcp_off;
      fr_q   <= in_fin_rst;
    end else if (issue) begin
      idx_q <= idx_q + 1'b1;
      if (in_last) st_q <= SEQ_HEAD;
    end
  end

endmodule

// File: rtl/flow_stream_oreg.sv
module flow_stream_oreg
  import flow_stream_pkg::*;
#(
  parameter int FLOW_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [WORD_W-1:0]  d_data,
  input  mark_t              d_mark,
  input  logic [NBYTE_W-1:0] d_nbytes,
  input  logic [FLOW_W-1:0]  d_flow,
  input  fev_t               d_fev,
  output logic               q_en,
  output logic [WORD_W-1:0]  q_data,
  output mark_t              q_mark,
  output logic [NBYTE_W-1:0] q_nbytes,
  output logic [FLOW_W-1:0]  q_flow,
  output fev_t               q_fev
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_en     <= 1'b0;
      q_data   <= '0;
      q_mark   <= '0;
      q_nbytes <= '0;
      q_flow   <= '0;
      q_fev    <= '0;
    end else begin
      q_en <= load;
      if (load) begin
        q_data   <= d_data;
        q_mark   <= d_mark;
        q_nbytes <= d_nbytes;
        q_flow   <= d_flow;
        q_fev    <= d_fev;
      end
    end
  end

endmodule

// File: rtl/flow_stream_out.sv
module flow_stream_out
  import flow_stream_pkg::*;
#(
  parameter int FLOWS = 256,
  parameter int LEN_W = 16,
  parameter int OFF_W = 4,
  localparam int FLOW_W = $clog2(FLOWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              client_go,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_data,
  input  logic              in_last,
  input  logic [FLOW_W-1:0] in_flow,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [OFF_W-1:0]  in_ip_off,
  input  logic [OFF_W-1:0]  in_tcp_off,
  input  logic              in_fin_rst,
  input  logic              note_valid,
  input  logic [FLOW_W-1:0] note_flow,
  output logic              out_en,
  output logic [31:0]       out_data,
  output logic [3:0]        out_mark,
  output logic [1:0]        out_nbytes,
  output logic [FLOW_W-1:0] out_flow,
  output logic [1:0]        out_flow_ev
);

  logic               take;
  logic               issue;
  logic               start_hit;
  logic [WORD_W-1:0]  nx_data;
  mark_t              nx_mark;
  logic [NBYTE_W-1:0] nx_nbytes;
  logic [FLOW_W-1:0]  nx_flow;
  fev_t               nx_fev;
  mark_t              q_mark;
  fev_t               q_fev;

  flow_start_table #(.FLOWS(FLOWS), .FLOW_W(FLOW_W)) u_table (
    .clk        (clk),
    .rst        (rst),
    .note_valid (note_valid),
    .note_flow  (note_flow),
    .take       (take),
    .take_flow  (in_flow),
    .start_hit  (start_hit)
  );

  flow_stream_seq #(.FLOW_W(FLOW_W), .LEN_W(LEN_W), .OFF_W(OFF_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .client_go  (client_go),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .in_last    (in_last),
    .in_flow    (in_flow),
    .in_len     (in_len),
    .in_ip_off  (in_ip_off),
    .in_tcp_off (in_tcp_off),
    .in_fin_rst (in_fin_rst),
    .start_hit  (start_hit),
    .take       (take),
    .issue      (issue),
    .nx_data    (nx_data),
    .nx_mark    (nx_mark),
    .nx_nbytes  (nx_nbytes),
    .nx_flow    (nx_flow),
    .nx_fev     (nx_fev)
  );

  flow_stream_oreg #(.FLOW_W(FLOW_W)) u_oreg (
    .clk      (clk),
    .rst      (rst),
    .load     (issue),
    .d_data   (nx_data),
    .d_mark   (nx_mark),
    .d_nbytes (nx_nbytes),
    .d_flow   (nx_flow),
    .d_fev    (nx_fev),
    .q_en     (out_en),
    .q_data   (out_data),
    .q_mark   (q_mark),
    .q_nbytes (out_nbytes),
    .q_flow   (out_flow),
    .q_fev    (q_fev)
  );

  assign out_mark    = q_mark;
  assign out_flow_ev = q_fev;

endmodule

// File: rtl/flow_stream_out_chk.sv
module flow_stream_out_chk #(
  parameter int FLOW_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              client_go,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_en,
  input logic [31:0]       out_data,
  input logic [3:0]        out_mark,
  input logic [1:0]        out_nbytes,
  input logic [FLOW_W-1:0] out_flow,
  input logic [1:0]        out_flow_ev
);

  logic past_ok;
  logic in_frame;

  always_ff @(posedge clk) begin
    if (rst) begin
      past_ok  <= 1'b0;
      in_frame <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (out_en && out_mark[3]) in_frame <= 1'b0;
      else if (out_en && out_mark[0]) in_frame <= 1'b1;
    end
  end

  // R5
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(client_go) |-> !out_en && $stable(out_data) &&
      $stable(out_mark) && $stable(out_nbytes) && $stable(out_flow) &&
      $stable(out_flow_ev));

  // R5
  ready_needs_go_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> client_go);

  // R6
  accept_to_output_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_en);

  // R3
  frame_open_chk: assert property (@(posedge clk) disable iff (rst)
    out_en && out_mark[0] |-> !in_frame && out_mark[3:1] == 3'b000);

  // R3
  frame_body_chk: assert property (@(posedge clk) disable iff (rst)
    out_en && !out_mark[0] |-> in_frame);

  // R4
  tail_only_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    out_en && !out_mark[3] |-> out_nbytes == 2'b00);

  // R9
  flow_end_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    out_en && out_flow_ev[1] |-> out_mark[3]);

  // R7
  flow_start_at_open_chk: assert property (@(posedge clk) disable iff (rst)
    out_en && out_flow_ev[0] |-> out_mark[0]);

endmodule

bind flow_stream_out flow_stream_out_chk #(.FLOW_W(FLOW_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .client_go   (client_go),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_en      (out_en),
  .out_data    (out_data),
  .out_mark    (out_mark),
  .out_nbytes  (out_nbytes),
  .out_flow    (out_flow),
  .out_flow_ev (out_flow_ev)
);

// File: tb/tb_flow_stream_out.sv
module tb_flow_stream_out;

  localparam int HALF = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        client_go = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        in_last = 1'b0;
  logic [7:0]  in_flow = '0;
  logic [15:0] in_len = '0;
  logic [3:0]  in_ip_off = '0;
  logic [3:0]  in_tcp_off = '0;
  logic        in_fin_rst = 1'b0;
  logic        note_valid = 1'b0;
  logic [7:0]  note_flow = '0;
  logic        out_en;
  logic [31:0] out_data;
  logic [3:0]  out_mark;
  logic [1:0]  out_nbytes;
  logic [7:0]  out_flow;
  logic [1:0]  out_flow_ev;

  int total = 0;
  int bad = 0;
  int go_mode = 0;
  logic hold_on = 1'b0;
  logic go_at_edge = 1'b1;
  logic [7:0] lfsr = 8'h5a;
  logic [31:0] prev_data = '0;
  logic [7:0] tag = '0;

  always #HALF clk = ~clk;

  flow_stream_out dut (
    .clk(clk), .rst(rst), .client_go(client_go),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .in_flow(in_flow), .in_len(in_len),
    .in_ip_off(in_ip_off), .in_tcp_off(in_tcp_off), .in_fin_rst(in_fin_rst),
    .note_valid(note_valid), .note_flow(note_flow),
    .out_en(out_en), .out_data(out_data), .out_mark(out_mark),
    .out_nbytes(out_nbytes), .out_flow(out_flow), .out_flow_ev(out_flow_ev)
  );

  // fields: flow[34:27] len[26:11] ip[10:7] tcp[6:3] fin_rst[2] syn[1] exp_start[0]
  localparam logic [34:0] VEC [0:7] = '{
    {8'd5,   16'd20, 4'd1, 4'd3, 1'b0, 1'b1, 1'b1},
    {8'd5,   16'd23, 4'd1, 4'd2, 1'b0, 1'b0, 1'b0},
    {8'd9,   16'd13, 4'd0, 4'd0, 1'b1, 1'b0, 1'b0},
    {8'd9,   16'd18, 4'd2, 4'd4, 1'b0, 1'b1, 1'b1},
    {8'd200, 16'd4,  4'd0, 4'd0, 1'b1, 1'b1, 1'b1},
    {8'd255, 16'd40, 4'd2, 4'd5, 1'b1, 1'b0, 1'b0},
    {8'd5,   16'd9,  4'd0, 4'd1, 1'b1, 1'b1, 1'b1},
    {8'd0,   16'd2,  4'd0, 4'd0, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (go_mode == 1) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      client_go = lfsr[0] | lfsr[3];
    end else if (go_mode == 0) begin
      client_go = 1'b1;
    end
  end

  always @(posedge clk) go_at_edge <= client_go;

  always @(negedge clk) begin
    if (hold_on && !rst && !go_at_edge) begin
      chk("R5 out_en low after stall", {63'd0, out_en}, 64'd0);
      chk("R5 out_data held in stall", {32'd0, out_data}, {32'd0, prev_data});
    end
    prev_data = out_data;
  end

  task automatic send_note(input logic [7:0] f);
    note_flow  = f;
    note_valid = 1'b1;
    @(negedge clk);
    note_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic drive_pkt(input logic [7:0] f, input logic [15:0] len,
                           input logic [3:0] ip, input logic [3:0] tcp,
                           input logic fr, input logic [7:0] t);
    int nw;
    logic acc;
    bit first;
    nw = (int'(len) + 3) / 4;
    in_flow = f; in_len = len; in_ip_off = ip; in_tcp_off = tcp; in_fin_rst = fr;
    for (int w = 0; w < nw; w++) begin
      in_valid = 1'b1;
      in_data  = {f, t, 16'(w)};
      in_last  = (w == nw - 1);
      first    = (w == 0);
      do begin
        #5;
        acc = in_ready;
        if (first) chk("R6 in_ready low while length word issues", {63'd0, acc}, 64'd0);
        first = 1'b0;
        @(negedge clk);
      end while (!acc);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic check_pkt(input logic [7:0] f, input logic [15:0] len,
                           input logic [3:0] ip, input logic [3:0] tcp,
                           input logic fr, input logic st, input logic [7:0] t);
    int nw;
    int k;
    int w;
    logic [3:0] em;
    logic [1:0] en;
    logic [1:0] ev;
    logic [31:0] ed;
    nw = (int'(len) + 3) / 4;
    k = 0;
    while (k < nw + 1) begin
      @(negedge clk);
      if (out_en) begin
        if (k == 0) begin
          ed = {16'd0, len}; em = 4'b0001; en = 2'd0; ev = {1'b0, st};
        end else begin
          w  = k - 1;
          ed = {f, t, 16'(w)};
          em = {(w == nw - 1), (w == int'(tcp)), (w == int'(ip)), 1'b0};
          en = (w == nw - 1) ? len[1:0] : 2'd0;
          ev = {(w == nw - 1) && fr, 1'b0};
        end
        chk("R2 data", {32'd0, out_data}, {32'd0, ed});
        chk("R2 flow", {56'd0, out_flow}, {56'd0, f});
        chk("R3 markers", {60'd0, out_mark}, {60'd0, em});
        chk("R4 valid bytes", {62'd0, out_nbytes}, {62'd0, en});
        chk("R7 R9 R10 flow events", {62'd0, out_flow_ev}, {62'd0, ev});
        k++;
      end
    end
  endtask

  task automatic run_pkt(input logic [7:0] f, input logic [15:0] len,
                         input logic [3:0] ip, input logic [3:0] tcp,
                         input logic fr, input logic st);
    tag = tag + 1'b1;
    fork
      drive_pkt(f, len, ip, tcp, fr, tag);
      check_pkt(f, len, ip, tcp, fr, st, tag);
    join
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R2 act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 out_en in reset", {63'd0, out_en}, 64'd0);
    chk("R1 out_mark in reset", {60'd0, out_mark}, 64'd0);
    chk("R1 out_flow_ev in reset", {62'd0, out_flow_ev}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 in_ready after reset", {63'd0, in_ready}, 64'd0);
    chk("R1 out_en after reset", {63'd0, out_en}, 64'd0);

    // table walk: odd entries under random client stalls
    for (int i = 0; i < 8; i++) begin
      go_mode = (i % 2 == 1) ? 1 : 0;
      hold_on = (go_mode == 1);
      @(negedge clk);
      if (VEC[i][1]) send_note(VEC[i][34:27]);
      run_pkt(VEC[i][34:27], VEC[i][26:11], VEC[i][10:7], VEC[i][6:3],
              VEC[i][2], VEC[i][0]);
    end
    go_mode = 0;
    hold_on = 1'b0;
    repeat (2) @(negedge clk);

    // R8: notice in the same cycle the header is taken
    note_flow  = 8'd77;
    note_valid = 1'b1;
    fork
      run_pkt(8'd77, 16'd10, 4'd0, 4'd1, 1'b0, 1'b1);
      begin @(negedge clk); note_valid = 1'b0; end
    join
    // R7: consumed, so the next packet on the flow has no start flag
    run_pkt(8'd77, 16'd8, 4'd0, 4'd1, 1'b0, 1'b0);

    // R5: directed mid-packet stall
    go_mode = 2;
    hold_on = 1'b1;
    @(negedge clk);
    fork
      run_pkt(8'd3, 16'd16, 4'd1, 4'd2, 1'b1, 1'b0);
      begin
        repeat (2) @(negedge clk);
        client_go = 1'b0;
        #5;
        chk("R5 in_ready low while go low", {63'd0, in_ready}, 64'd0);
        repeat (3) @(negedge clk);
        client_go = 1'b1;
      end
    join
    hold_on = 1'b0;
    go_mode = 0;
    repeat (3) @(negedge clk);
    chk("R6 idle with no input", {63'd0, out_en}, 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule